// File: doc/BRIEF.md
# Open-Drain Two-Wire Bus Master with Coded Fault Capture

This block drives a two-wire serial bus as its only master. It forms START and STOP conditions and moves single bytes to and from a memory-style slave. Software-side logic gives it one command at a time on a valid/ready port. Each command plays out as a fixed list of bus phases. Every phase lasts a programmable number of timing-strobe ticks.

The block never drives a line high. It has one pull-low enable per line and reads each line back through a sampling input. It checks those read-back levels at fixed points in each sequence. The first fault it finds is kept as a small numeric code, so a diagnostic routine can tell a stuck clock, a stuck data line, a missing acknowledge and a failed STOP apart. Later faults never replace that first code. It is cleared only by reset or by an explicit clear command.

A typical transfer is START, a write of the slave address byte, further write or read commands, then STOP. The address byte is `1010`, then three device-select bits, then the read/write bit in the least significant position.

Top module: `i2c_fault_master`

## Requirements
- R1: During and after synchronous reset, both pull-low enables are 0 (lines released), `cmd_ready` is 1, `err_flag` is 0 and `err_code` is 0.
- R2: Op code 1 (START) runs three phases, with (scl_oe, sda_oe) equal to (0,0), then (0,1), then (1,1). A phase lasts `phase_len` ticks, and a `phase_len` of 0 acts as 1.
- R3: Op code 2 (STOP) runs three phases: (1,1), then (0,1), then (0,0).
- R4: Op code 3 (WRITE) sends `cmd_wdata` MSB first as nine bit slots followed by one tail phase. Each slot is a phase with SCL pulled low and then a phase with SCL released, and the SDA enable is the inverse of the bit and is the same across both phases of a slot, so SDA changes only while SCL is low. Slot nine releases SDA, and `rsp_ack` returns 1 when SDA was low at the end of its released-SCL phase. The tail phase is (1,0).
- R5: Op codes 4 (read with ACK) and 5 (read with NACK) release SDA for eight slots and shift SDA in MSB first, sampling at the end of each released-SCL phase; the byte appears on `rsp_rdata`. In slot nine SDA is pulled low for op 4 and released for op 5. The tail phase is (1,0).
- R6: Code 1 is raised when SCL reads low at the end of START phase one or STOP phase two.
- R7: Code 2 is raised when SDA reads low at the end of START phase one while SCL reads high.
- R8: Code 3 is raised when SDA reads high at the end of the ninth released-SCL phase of a WRITE.
- R9: Code 4 is raised when SDA reads low at the end of STOP phase three.
- R10: Once `err_flag` is set, later faults change neither the flag nor `err_code`.
- R11: Op code 6 (CLEAR), accepted while idle, sets `err_flag` and `err_code` to 0 at the accepting edge, and `cmd_ready` stays 1.
- R12: A command with op 1 to 5 is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. From that edge, `cmd_ready` stays 0 and the lines step through the phases. After phases × phase length ticks, `rsp_valid` pulses for exactly one cycle and `cmd_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing strobe; one count of a phase |
| phase_len | input | CNT_W | Ticks per bus phase (0 treated as 1) |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (1..6) |
| cmd_wdata | input | DATA_W | Byte to send for WRITE |
| cmd_ready | output | 1 | Idle and able to take a command |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Byte received by the last read |
| rsp_ack | output | 1 | Acknowledge seen by the last write |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| err_flag | output | 1 | A fault has been captured |
| err_code | output | 3 | First captured fault code (0 when none) |

## Verification
With the strobe high on every cycle, phase k of a command, counted from zero, sets the line enables just after edge k·L, where the accepting edge is edge zero. The bench models this as a list of expected enable pairs, each repeated L times. It compares that list against the outputs at every falling edge between acceptance and completion. `rsp_valid`, the response data and any fault code raised during the command are all due after the edge N·L, where N is the number of phases, so those values are checked one half-cycle after that edge. A clear takes effect after its accepting edge and is checked at the next falling edge. The simulated slave changes its pull-down only at falling edges, so each sampling edge sees a settled level.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_START   = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_RD_ACK  = 3'd4,
    OP_RD_NACK = 3'd5,
    OP_CLEAR   = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    SMP_NONE,
    SMP_START,
    SMP_SCL,
    SMP_STOP_SDA,
    SMP_ACK,
    SMP_RDBIT
  } smp_e;

  localparam logic [2:0] FC_SCL_LOW  = 3'd1;
  localparam logic [2:0] FC_SDA_LOW  = 3'd2;
  localparam logic [2:0] FC_NO_ACK   = 3'd3;
  localparam logic [2:0] FC_STOP_SDA = 3'd4;

  typedef struct packed {
    logic scl_low;
    logic sda_low;
    smp_e smp;
    logic last;
  } step_t;

endpackage

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] len,
  output logic             phase_end
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_m1;

  assign len_m1    = (len == '0) ? '0 : len - CNT_W'(1);
  assign phase_end = run && tick && (cnt == len_m1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= phase_end ? '0 : cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/i2cm_step_decode.sv
module i2cm_step_decode
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STEP_W = 5
) (
  input  op_e               op,
  input  logic [STEP_W-1:0] step,
  input  logic [DATA_W-1:0] wdata,
  output step_t             st
);
  localparam int BYTE_STEPS = 2 * (DATA_W + 1) + 1;
  localparam logic [STEP_W-1:0] TAIL_STEP = STEP_W'(BYTE_STEPS - 1);

  int               slot;
  logic             hi_phase;
  logic [DATA_W-1:0] shifted;
  logic             is_wr;

  always_comb begin
    st.scl_low = 1'b0;
    st.sda_low = 1'b0;
    st.smp     = SMP_NONE;
    st.last    = 1'b0;
    slot       = int'(step >> 1);
    hi_phase   = step[0];
    shifted    = wdata << slot;
    is_wr      = (op == OP_WRITE);
    case (op)
      OP_START: begin
        if (step == '0) begin
          st.smp = SMP_START;
        end else if (step == STEP_W'(1)) begin
          st.sda_low = 1'b1;
        end else begin
          st.scl_low = 1'b1;
          st.sda_low = 1'b1;
          st.last    = 1'b1;
        end
      end
      OP_STOP: begin
        if (step == '0) begin
          st.scl_low = 1'b1;
          st.sda_low = 1'b1;
        end else if (step == STEP_W'(1)) begin
          st.sda_low = 1'b1;
          st.smp     = SMP_SCL;
        end else begin
          st.smp  = SMP_STOP_SDA;
          st.last = 1'b1;
        end
      end
      OP_WRITE, OP_RD_ACK, OP_RD_NACK: begin
        if (step == TAIL_STEP) begin
          st.scl_low = 1'b1;
          st.last    = 1'b1;
        end else begin
          st.scl_low = !hi_phase;
          if (slot < DATA_W) begin
            st.sda_low = is_wr ? !shifted[DATA_W-1] : 1'b0;
            st.smp     = (hi_phase && !is_wr) ? SMP_RDBIT : SMP_NONE;
          end else begin
            st.sda_low = (op == OP_RD_ACK);
            st.smp     = (hi_phase && is_wr) ? SMP_ACK : SMP_NONE;
          end
        end
      end
      default: st.last = 1'b1;
    endcase
  end
endmodule

// File: rtl/i2cm_fault_latch.sv
module i2cm_fault_latch (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       raise,
  input  logic [2:0] code_in,
  output logic       flag,
  output logic [2:0] code
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      flag <= 1'b0;
      code <= 3'd0;
    end else if (raise && !flag) begin
      flag <= 1'b1;
      code <= code_in;
    end
  end
endmodule

// File: rtl/i2c_fault_master.sv
module i2c_fault_master
  import i2cm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CNT_W-1:0]  phase_len,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_ack,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              err_flag,
  output logic [2:0]        err_code
);
  localparam int BYTE_STEPS = 2 * (DATA_W + 1) + 1;
  localparam int STEP_W     = $clog2(BYTE_STEPS);

  logic              busy;
  op_e               op_q;
  logic [DATA_W-1:0] wdata_q;
  logic [STEP_W-1:0] step_q;
  step_t             st_q;
  logic [DATA_W-1:0] shreg;

  op_e               op_d;
  logic [STEP_W-1:0] step_d;
  logic [DATA_W-1:0] wdata_d;
  step_t             st_d;

  logic              phase_end;
  logic              accept;
  logic              clear_cmd;
  logic              advance;
  logic              raise;
  logic [2:0]        raise_code;

  assign accept    = cmd_valid && !busy && (cmd_op >= 3'd1) && (cmd_op <= 3'd5);
  assign clear_cmd = cmd_valid && !busy && (cmd_op == 3'd6);
  assign advance   = busy && phase_end;
  assign cmd_ready = !busy;
  assign scl_oe    = st_q.scl_low;
  assign sda_oe    = st_q.sda_low;

  always_comb begin
    if (accept) begin
      op_d    = op_e'(cmd_op);
      step_d  = '0;
      wdata_d = cmd_wdata;
    end else begin
      op_d    = op_q;
      step_d  = step_q + STEP_W'(1);
      wdata_d = wdata_q;
    end
  end

  i2cm_step_decode #(.DATA_W(DATA_W), .STEP_W(STEP_W)) u_decode (
    .op    (op_d),
    .step  (step_d),
    .wdata (wdata_d),
    .st    (st_d)
  );

  i2cm_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run       (busy),
    .tick      (tick),
    .len       (phase_len),
    .phase_end (phase_end)
  );

  always_comb begin
    raise      = 1'b0;
    raise_code = 3'd0;
    if (advance) begin
      case (st_q.smp)
        SMP_START: begin
          if (!scl_in) begin
            raise = 1'b1; raise_code = FC_SCL_LOW;
          end else if (!sda_in) begin
            raise = 1'b1; raise_code = FC_SDA_LOW;
          end
        end
        SMP_SCL: begin
          if (!scl_in) begin
            raise = 1'b1; raise_code = FC_SCL_LOW;
          end
        end
        SMP_STOP_SDA: begin
          if (!sda_in) begin
            raise = 1'b1; raise_code = FC_STOP_SDA;
          end
        end
        SMP_ACK: begin
          if (sda_in) begin
            raise = 1'b1; raise_code = FC_NO_ACK;
          end
        end
        default: ;
      endcase
    end
  end

  i2cm_fault_latch u_fault (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear_cmd),
    .raise   (raise),
    .code_in (raise_code),
    .flag    (err_flag),
    .code    (err_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      op_q       <= OP_NONE;
      wdata_q    <= '0;
      step_q     <= '0;
      st_q       <= '{scl_low: 1'b0, sda_low: 1'b0, smp: SMP_NONE, last: 1'b0};
      shreg      <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_ack    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept || (advance && !st_q.last)) begin
        op_q    <= op_d;
        step_q  <= step_d;
        wdata_q <= wdata_d;
        st_q    <= st_d;
      end
      if (accept) begin
        busy <= 1'b1;
      end else if (advance) begin
        if (st_q.smp == SMP_RDBIT) begin
          shreg <= {shreg[DATA_W-2:0], sda_in};
        end
        if (st_q.smp == SMP_ACK) begin
          rsp_ack <= !sda_in;
        end
        if (st_q.last) begin
          busy      <= 1'b0;
          rsp_valid <= 1'b1;
          if (op_q == OP_RD_ACK || op_q == OP_RD_NACK) begin
            rsp_rdata <= shreg;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       cmd_ready,
  input logic       rsp_valid,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       err_flag,
  input logic [2:0] err_code
);
  a_r1_released_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!scl_oe && !sda_oe && !err_flag && cmd_ready));

  a_r10_first_fault_kept: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !(cmd_valid && cmd_ready && cmd_op == 3'd6)) |=> (err_flag && $stable(err_code)));

  a_r11_clear_status: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 3'd6) |=> (!err_flag && err_code == 3'd0 && cmd_ready));

  a_r11_no_code_without_flag: assert property (@(posedge clk) disable iff (rst)
    !err_flag |-> (err_code == 3'd0));

  a_r6_code_legal: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (err_code >= 3'd1 && err_code <= 3'd4));

  a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op >= 3'd1 && cmd_op <= 3'd5) |=> !cmd_ready);

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r12_ready_with_response: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> cmd_ready);
endmodule

bind i2c_fault_master i2cm_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .err_flag  (err_flag),
  .err_code  (err_code)
);

// File: tb/tb_i2c_fault_master.sv
module tb_i2c_fault_master;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst = 1'b1;
  logic              tick = 1'b1;
  logic [CNT_W-1:0]  phase_len = 8'd2;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_op = 3'd0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic              cmd_ready, rsp_valid, rsp_ack, scl_oe, sda_oe, err_flag;
  logic [DATA_W-1:0] rsp_rdata;
  logic [2:0]        err_code;
  logic              scl_in, sda_in;

  logic hold_scl = 1'b0, hold_sda = 1'b0, pull_sda = 1'b0;
  assign scl_in = !(scl_oe || hold_scl);
  assign sda_in = !(sda_oe || hold_sda || pull_sda);

  int checks = 0;
  int fails  = 0;
  logic       exp_flag = 1'b0;
  logic [2:0] exp_code = 3'd0;
  bit finished = 0;

  i2c_fault_master #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .tick(tick), .phase_len(phase_len),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in), .sda_in(sda_in),
    .err_flag(err_flag), .err_code(err_code)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected (scl_oe, sda_oe) per phase, built from R2..R5.
  task automatic run_cmd(input logic [2:0] op, input logic [7:0] wd, input int len,
                         input logic [7:0] slave_rd, input logic slave_ack,
                         input logic [2:0] fault, input string req);
    logic [1:0] ph[$];
    int leff;
    leff = (len == 0) ? 1 : len;
    if (op == 3'd1) begin
      ph.push_back(2'b00); ph.push_back(2'b01); ph.push_back(2'b11);
    end else if (op == 3'd2) begin
      ph.push_back(2'b11); ph.push_back(2'b01); ph.push_back(2'b00);
    end else begin
      for (int bi = 0; bi < 9; bi++) begin
        logic d;
        if (bi < 8) d = (op == 3'd3) ? !wd[7-bi] : 1'b0;
        else        d = (op == 3'd4);
        ph.push_back({1'b1, d});
        ph.push_back({1'b0, d});
      end
      ph.push_back(2'b10);
    end
    @(negedge clk);
    phase_len = CNT_W'(len);
    cmd_op    = op;
    cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(posedge clk);
    for (int j = 0; j < ph.size() * leff; j++) begin
      int p;
      @(negedge clk);
      cmd_valid = 1'b0;
      p = j / leff;
      check({req, " R12 busy"}, {31'd0, cmd_ready}, 32'd0);
      check({req, " R12 no early response"}, {31'd0, rsp_valid}, 32'd0);
      check({req, " line enables"}, {30'd0, scl_oe, sda_oe}, {30'd0, ph[p]});
      pull_sda = 1'b0;
      if ((op == 3'd4 || op == 3'd5) && (p / 2) < 8) pull_sda = !slave_rd[7 - (p / 2)];
      if (op == 3'd3 && (p / 2) == 8 && p < 18) pull_sda = slave_ack;
      @(posedge clk);
    end
    @(negedge clk);
    pull_sda = 1'b0;
    if (fault != 3'd0 && !exp_flag) begin
      exp_flag = 1'b1;
      exp_code = fault;
    end
    check({req, " R12 response pulse"}, {31'd0, rsp_valid}, 32'd1);
    check({req, " R12 ready again"}, {31'd0, cmd_ready}, 32'd1);
    check({req, " final enables"}, {30'd0, scl_oe, sda_oe}, {30'd0, ph[ph.size()-1]});
    check({req, " R10 error flag"}, {31'd0, err_flag}, {31'd0, exp_flag});
    check({req, " R10 error code"}, {29'd0, err_code}, {29'd0, exp_code});
    if (op == 3'd3) check({req, " R4 ack result"}, {31'd0, rsp_ack}, {31'd0, slave_ack});
    if (op == 3'd4 || op == 3'd5) check({req, " R5 read byte"}, {24'd0, rsp_rdata}, {24'd0, slave_rd});
    @(negedge clk);
    check({req, " R12 pulse is one cycle"}, {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic clear_status(input string req);
    @(negedge clk);
    cmd_op    = 3'd6;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    exp_flag  = 1'b0;
    exp_code  = 3'd0;
    check({req, " R11 flag cleared"}, {31'd0, err_flag}, 32'd0);
    check({req, " R11 code cleared"}, {29'd0, err_code}, 32'd0);
    check({req, " R11 ready kept"}, {31'd0, cmd_ready}, 32'd1);
  endtask

  initial begin
    #(200_000 * 10);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 scl released in reset", {31'd0, scl_oe}, 32'd0);
    check("R1 sda released in reset", {31'd0, sda_oe}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", {31'd0, cmd_ready}, 32'd1);
    check("R1 flag after reset", {31'd0, err_flag}, 32'd0);
    check("R1 code after reset", {29'd0, err_code}, 32'd0);

    run_cmd(3'd1, 8'h00, 2, 8'h00, 1'b0, 3'd0, "R2 start");
    run_cmd(3'd3, 8'b1010_011_0, 2, 8'h00, 1'b1, 3'd0, "R4 address write");
    run_cmd(3'd4, 8'h00, 2, 8'h3C, 1'b0, 3'd0, "R5 read ack");
    run_cmd(3'd5, 8'h00, 3, 8'hC3, 1'b0, 3'd0, "R5 read nack");
    run_cmd(3'd2, 8'h00, 2, 8'h00, 1'b0, 3'd0, "R3 stop");
    run_cmd(3'd1, 8'h00, 0, 8'h00, 1'b0, 3'd0, "R2 zero length start");
    run_cmd(3'd3, 8'h5A, 1, 8'h00, 1'b0, 3'd3, "R8 no ack");
    hold_sda = 1'b1;
    run_cmd(3'd2, 8'h00, 2, 8'h00, 1'b0, 3'd4, "R10 second fault ignored");
    hold_sda = 1'b0;
    clear_status("R11 clear after no ack");

    hold_scl = 1'b1;
    run_cmd(3'd1, 8'h00, 2, 8'h00, 1'b0, 3'd1, "R6 start scl stuck");
    hold_scl = 1'b0;
    clear_status("R11 clear after scl");

    hold_sda = 1'b1;
    run_cmd(3'd1, 8'h00, 2, 8'h00, 1'b0, 3'd2, "R7 start sda stuck");
    hold_sda = 1'b0;
    clear_status("R11 clear after sda");

    hold_sda = 1'b1;
    run_cmd(3'd2, 8'h00, 2, 8'h00, 1'b0, 3'd4, "R9 stop sda stuck");
    hold_sda = 1'b0;
    clear_status("R11 clear after stop");

    hold_scl = 1'b1;
    run_cmd(3'd2, 8'h00, 1, 8'h00, 1'b0, 3'd1, "R6 stop scl stuck");
    hold_scl = 1'b0;
    clear_status("R11 final clear");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule